// File: doc/BRIEF.md
# Smart Card Interface Status Register

This block holds the read-only status byte of a smart card UART interface. It collects five pieces of status: a flag showing that the receive FIFO is empty, the synchronized card presence contact, a guard-time flag, a flag for a completed clock switch, and a combined "transmit empty / receive full" flag. The UART, FIFO and clock controller report to it through single-cycle event pulses. Software reads the byte through a simple addressed read port. None of these bits drives an interrupt.

The guard-time flag comes from a counter of elementary time units (ETUs). The counter restarts at every start bit it sees on the card I/O line. Its limit depends on the protocol: 16 ETU for the character protocol and 22 ETU for the block protocol. The flag is raised once the count reaches the limit before the next start bit arrives, which tells the host that the required silence has passed. The transmit-empty/receive-full flag follows a fixed list of set events and clear events, with one exception: the final character of a transfer, when sent without a parity error, does not set it.

Top module: `card_status_reg`

## Requirements
- R1: After power-on reset, a read of the status address returns 0x40. Only the FIFO-empty bit is set while the card contact reads absent.
- R2: When `rd_en` is high at a clock edge, `rd_valid` is high and `rd_data` holds the status after that edge. At address 0x0C the byte has clock-switch at bit 7, FIFO-empty at bit 6, guard-time at bit 5, presence at bit 2 and transmit-empty/receive-full at bit 0.
- R3: A start bit is a high-to-low change of `io_raw` after a two-flop synchronizer. It clears the guard-time bit and restarts the count from zero.
- R4: The guard-time bit sets once the count reaches 16 ETU ticks with `t1_mode`=0, or 22 ETU ticks with `t1_mode`=1. The count then saturates and the bit stays set until the next start bit.
- R5: The counter advances only in cycles where `etu_tick` is high.
- R6: The FIFO-empty bit is 1 whenever the push/pop balance is zero, and 0 once at least one character is held. The occupancy never exceeds FIFO_DEPTH.
- R7: The presence bit follows `card_present_raw` through a two-flop synchronizer.
- R8: The transmit-empty/receive-full bit sets on `enter_tx`, on `rx_buf_full`, or on `tx_char_done`.
- R9: A `tx_char_done` with `last_char_ctl`=1 and `tx_parity_err`=0 does not set the transmit-empty/receive-full bit.
- R10: The transmit-empty/receive-full bit clears on `tx_reg_write`, `rx_reg_read` or `enter_rx`. A set event in the same cycle wins over these clears.
- R11: While `intf_rst` is high, the transmit-empty/receive-full bit and the clock-switch bit clear, whatever set events arrive.
- R12: The clock-switch bit sets on `clk_half_done` and clears on `clk_xtal_done`. A set wins when both arrive in the same cycle.
- R13: Bits 4, 3 and 1 read as 0. A read at any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| intf_rst | input | 1 | Interface reset level |
| etu_tick | input | 1 | One-cycle strobe per elementary time unit |
| io_raw | input | 1 | Card I/O line, asynchronous, idle high |
| t1_mode | input | 1 | 1 = block protocol (22 ETU), 0 = character protocol (16 ETU) |
| card_present_raw | input | 1 | Card presence contact, asynchronous |
| enter_tx | input | 1 | Pulse: switched from reception to transmission |
| enter_rx | input | 1 | Pulse: switched from transmission to reception |
| tx_char_done | input | 1 | Pulse: UART finished sending a character |
| tx_parity_err | input | 1 | Parity error flag for the character that just finished |
| last_char_ctl | input | 1 | Last-character control setting |
| rx_buf_full | input | 1 | Pulse: receive buffer became full |
| tx_reg_write | input | 1 | Pulse: transmit register written |
| rx_reg_read | input | 1 | Pulse: receive register read |
| fifo_push | input | 1 | Pulse: character loaded into the receive FIFO |
| fifo_pop | input | 1 | Pulse: character taken from the receive FIFO |
| clk_half_done | input | 1 | Pulse: switch to half internal clock completed |
| clk_xtal_done | input | 1 | Pulse: switch back to crystal clock completed |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |

## Verification
The guard counter is tested with ticks spread sparsely and densely, and with a start bit arriving both before and after the limit. This separates a counter that counts ticks from one that counts cycles, and a restart that happens from one that never happens. Switching the protocol mid-count shows whether the limit is chosen from `t1_mode` at the moment it is needed. Event pulses for the flags are sent alone and in colliding pairs, which separates set-wins, clear-wins and reset-dominance behaviour. The last-character case is sent with and without a parity error so that the exception can be told apart from an ordinary set.

// File: rtl/card_stat_pkg.sv
package card_stat_pkg;
  localparam int BIT_CLKSW = 7;
  localparam int BIT_FEMPTY = 6;
  localparam int BIT_GUARD = 5;
  localparam int BIT_PRES = 2;
  localparam int BIT_TXRX = 0;

  typedef struct packed {
    logic clksw;
    logic fifo_empty;
    logic guard_ok;
    logic present;
    logic txrx;
  } stat_t;

  function automatic logic [7:0] pack_status(input stat_t s);
    logic [7:0] b;
    b = 8'h00;
    b[BIT_CLKSW]  = s.clksw;
    b[BIT_FEMPTY] = s.fifo_empty;
    b[BIT_GUARD]  = s.guard_ok;
    b[BIT_PRES]   = s.present;
    b[BIT_TXRX]   = s.txrx;
    return b;
  endfunction
endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cs_guard_timer.sv
module cs_guard_timer #(
  parameter int T0_LIM = 16,
  parameter int T1_LIM = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic io_sync,
  input  logic t1_mode,
  input  logic etu_tick,
  output logic guard_done
);
  localparam int MAXL = (T0_LIM > T1_LIM) ? T0_LIM : T1_LIM;
  localparam int CW = $clog2(MAXL + 1);

  logic          io_prev;
  logic          start_seen;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim        = t1_mode ? CW'(T1_LIM) : CW'(T0_LIM);
  assign start_seen = io_prev & ~io_sync;
  assign guard_done = (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_prev <= 1'b1;
      cnt     <= '0;
    end else begin
      io_prev <= io_sync;
      if (start_seen) cnt <= '0;
      else if (etu_tick && (cnt < lim)) cnt <= cnt + CW'(1);
    end
  end

  // R3: a start bit restarts the count
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> (cnt == '0));
  // R4: one step per tick below the limit
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (etu_tick && !start_seen && (cnt < lim)) |=> (cnt == $past(cnt) + CW'(1)));
  // R4: saturation bound
  a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAXL));
  // R5: no tick, no advance
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!etu_tick && !start_seen) |=> $stable(cnt));
endmodule

// File: rtl/cs_event_flag.sv
module cs_event_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hard_clr,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (hard_clr) flag <= 1'b0;
    else if (set_evt)  flag <= 1'b1;
    else if (clr_evt)  flag <= 1'b0;
  end

  // R10 / R12: set wins over a clear in the same cycle
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && !hard_clr) |=> flag);
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt && !hard_clr) |=> !flag);
  // R11: interface reset dominates
  a_r11_hard_clr: assert property (@(posedge clk) disable iff (!rst_n)
    hard_clr |=> !flag);
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_evt && !clr_evt && !hard_clr) |=> $stable(flag));
endmodule

// File: rtl/cs_fifo_tracker.sv
module cs_fifo_tracker #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  output logic empty
);
  localparam int OW = $clog2(DEPTH + 1);

  logic [OW-1:0] occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else if (push && !pop && (occ < OW'(DEPTH))) occ <= occ + OW'(1);
    else if (pop && !push && (occ != '0)) occ <= occ - OW'(1);
  end

  assign empty = (occ == '0);

  // R6: occupancy bound and fill behaviour
  a_r6_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(DEPTH));
  a_r6_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> !empty);
endmodule

// File: rtl/card_status_reg.sv
module card_status_reg
  import card_stat_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int REG_ADDR = 12,
  parameter int T0_LIM = 16,
  parameter int T1_LIM = 22,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              intf_rst,
  input  logic              etu_tick,
  input  logic              io_raw,
  input  logic              t1_mode,
  input  logic              card_present_raw,
  input  logic              enter_tx,
  input  logic              enter_rx,
  input  logic              tx_char_done,
  input  logic              tx_parity_err,
  input  logic              last_char_ctl,
  input  logic              rx_buf_full,
  input  logic              tx_reg_write,
  input  logic              rx_reg_read,
  input  logic              fifo_push,
  input  logic              fifo_pop,
  input  logic              clk_half_done,
  input  logic              clk_xtal_done,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);
  logic [1:0] sync_q;
  logic       io_s;
  logic       pres_s;
  logic       guard_done;
  logic       fifo_empty;
  logic       txrx_set, txrx_clr, txrx_flag;
  logic       clksw_flag;
  logic       rd_hit;
  stat_t      st;

  cs_sync #(.W(2), .STAGES(2), .INIT(2'b01)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({card_present_raw, io_raw}), .q(sync_q));
  assign io_s   = sync_q[0];
  assign pres_s = sync_q[1];

  cs_guard_timer #(.T0_LIM(T0_LIM), .T1_LIM(T1_LIM)) u_guard (
    .clk(clk), .rst_n(rst_n), .io_sync(io_s), .t1_mode(t1_mode),
    .etu_tick(etu_tick), .guard_done(guard_done));

  cs_fifo_tracker #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .pop(fifo_pop),
    .empty(fifo_empty));

  // last character sent cleanly does not raise the flag
  assign txrx_set = enter_tx | rx_buf_full
                  | (tx_char_done & ~(last_char_ctl & ~tx_parity_err));
  assign txrx_clr = tx_reg_write | rx_reg_read | enter_rx;

  cs_event_flag u_txrx (
    .clk(clk), .rst_n(rst_n), .hard_clr(intf_rst), .set_evt(txrx_set),
    .clr_evt(txrx_clr), .flag(txrx_flag));

  cs_event_flag u_clksw (
    .clk(clk), .rst_n(rst_n), .hard_clr(intf_rst), .set_evt(clk_half_done),
    .clr_evt(clk_xtal_done), .flag(clksw_flag));

  always_comb begin
    st.clksw      = clksw_flag;
    st.fifo_empty = fifo_empty;
    st.guard_ok   = guard_done;
    st.present    = pres_s;
    st.txrx       = txrx_flag;
  end

  assign rd_hit = (rd_addr == ADDR_W'(REG_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_hit ? pack_status(st) : 8'h00;
    end
  end

  // R2: a read returns data one cycle later
  a_r2_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R13: unused positions stay zero
  a_r13_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data[4:3] == 2'b00 && !rd_data[1]));
  a_r13_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_hit) |=> (rd_data == 8'h00));
  // R9: clean last character alone leaves the flag clear
  a_r9_exception: assert property (@(posedge clk) disable iff (!rst_n)
    (!txrx_flag && tx_char_done && last_char_ctl && !tx_parity_err
     && !enter_tx && !rx_buf_full) |=> !txrx_flag);
endmodule

// File: tb/card_status_reg_bench.sv
module card_status_reg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic intf_rst = 0, etu_tick = 0, io_raw = 1, t1_mode = 0, card_present_raw = 0;
  logic enter_tx = 0, enter_rx = 0, tx_char_done = 0, tx_parity_err = 0;
  logic last_char_ctl = 0, rx_buf_full = 0, tx_reg_write = 0, rx_reg_read = 0;
  logic fifo_push = 0, fifo_pop = 0, clk_half_done = 0, clk_xtal_done = 0;
  logic rd_en = 0;
  logic [3:0] rd_addr = 4'hC;
  logic rd_valid;
  logic [7:0] rd_data;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_status_reg u_card_status_reg (
    .clk(clk), .rst_n(rst_n), .intf_rst(intf_rst), .etu_tick(etu_tick),
    .io_raw(io_raw), .t1_mode(t1_mode), .card_present_raw(card_present_raw),
    .enter_tx(enter_tx), .enter_rx(enter_rx), .tx_char_done(tx_char_done),
    .tx_parity_err(tx_parity_err), .last_char_ctl(last_char_ctl),
    .rx_buf_full(rx_buf_full), .tx_reg_write(tx_reg_write),
    .rx_reg_read(rx_reg_read), .fifo_push(fifo_push), .fifo_pop(fifo_pop),
    .clk_half_done(clk_half_done), .clk_xtal_done(clk_xtal_done),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data));

  // reference model state
  logic ms1, ms2, ms3, mp1, mp2, mtr, mck, fall;
  int mcnt, mocc, lim;
  logic [7:0] exp_rd;

  function automatic logic [7:0] exp_byte(input logic ck, input int occ,
                                          input int cnt, input int l,
                                          input logic pr, input logic tr);
    logic [7:0] b;
    b = 8'h00;
    b[7] = ck;
    b[6] = (occ == 0);
    b[5] = (cnt >= l);
    b[2] = pr;
    b[0] = tr;
    return b;
  endfunction

  function automatic logic next_flag(input logic cur, input logic hard,
                                     input logic s, input logic c);
    if (hard) return 1'b0;
    if (s) return 1'b1;
    if (c) return 1'b0;
    return cur;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms1 = 1; ms2 = 1; ms3 = 1; mp1 = 0; mp2 = 0; mtr = 0; mck = 0;
      mcnt = 0; mocc = 0; exp_rd = 8'h00;
    end else begin
      lim = t1_mode ? 22 : 16;
      if (rd_en) exp_rd = (rd_addr == 4'hC) ? exp_byte(mck, mocc, mcnt, lim, mp2, mtr) : 8'h00;
      fall = ms3 & ~ms2;
      if (fall) mcnt = 0;
      else if (etu_tick && mcnt < lim) mcnt = mcnt + 1;
      ms3 = ms2; ms2 = ms1; ms1 = io_raw;
      mp2 = mp1; mp1 = card_present_raw;
      if (fifo_push && !fifo_pop && mocc < DEPTH) mocc = mocc + 1;
      else if (fifo_pop && !fifo_push && mocc > 0) mocc = mocc - 1;
      mtr = next_flag(mtr, intf_rst,
                      enter_tx | rx_buf_full | (tx_char_done & ~(last_char_ctl & ~tx_parity_err)),
                      tx_reg_write | rx_reg_read | enter_rx);
      mck = next_flag(mck, intf_rst, clk_half_done, clk_xtal_done);
    end
  end

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // compare every field of the last read against the model
  task automatic check_fields();
    check("R12 clock-switch", {7'd0, rd_data[7]}, {7'd0, exp_rd[7]});
    check("R6 fifo-empty",    {7'd0, rd_data[6]}, {7'd0, exp_rd[6]});
    check("R4 guard",         {7'd0, rd_data[5]}, {7'd0, exp_rd[5]});
    check("R7 presence",      {7'd0, rd_data[2]}, {7'd0, exp_rd[2]});
    check("R8 txrx",          {7'd0, rd_data[0]}, {7'd0, exp_rd[0]});
    check("R13 unused",       {5'd0, rd_data[4:3], rd_data[1]}, 8'h00);
  endtask

  task automatic do_read(input logic [3:0] a);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0;
    check("R2 valid", {7'd0, rd_valid}, 8'h01);
    check_fields();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); etu_tick = 1;
      @(negedge clk); etu_tick = 0;
    end
  endtask

  task automatic start_bit();
    @(negedge clk); io_raw = 0;
    idle(4);
    io_raw = 1;
    idle(3);
  endtask

  task automatic clear_events();
    enter_tx = 0; enter_rx = 0; tx_char_done = 0; tx_parity_err = 0;
    last_char_ctl = 0; rx_buf_full = 0; tx_reg_write = 0; rx_reg_read = 0;
    fifo_push = 0; fifo_pop = 0; clk_half_done = 0; clk_xtal_done = 0;
    intf_rst = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    // R1: reset value
    do_read(4'hC);
    check("R1 reset value", rd_data, 8'h40);

    // R5: no ticks, guard stays low
    idle(40);
    do_read(4'hC);
    check("R5 no tick no count", {7'd0, rd_data[5]}, 8'h00);

    // R4: T0 limit 16
    t1_mode = 0;
    start_bit();
    ticks(15);
    do_read(4'hC);
    check("R4 t0 below limit", {7'd0, rd_data[5]}, 8'h00);
    ticks(1);
    do_read(4'hC);
    check("R4 t0 at limit", {7'd0, rd_data[5]}, 8'h01);
    ticks(5);
    do_read(4'hC);
    check("R4 saturated", {7'd0, rd_data[5]}, 8'h01);

    // R3: start bit clears guard
    start_bit();
    do_read(4'hC);
    check("R3 restart clears", {7'd0, rd_data[5]}, 8'h00);

    // R4: T1 limit 22
    t1_mode = 1;
    start_bit();
    ticks(21);
    do_read(4'hC);
    check("R4 t1 below limit", {7'd0, rd_data[5]}, 8'h00);
    ticks(1);
    do_read(4'hC);
    check("R4 t1 at limit", {7'd0, rd_data[5]}, 8'h01);

    // R9: clean last character does not set
    @(negedge clk); tx_char_done = 1; last_char_ctl = 1; tx_parity_err = 0;
    @(negedge clk); clear_events();
    do_read(4'hC);
    check("R9 clean last char", {7'd0, rd_data[0]}, 8'h00);
    @(negedge clk); tx_char_done = 1; last_char_ctl = 1; tx_parity_err = 1;
    @(negedge clk); clear_events();
    do_read(4'hC);
    check("R8 last char with parity error", {7'd0, rd_data[0]}, 8'h01);

    // R10: clear, then set wins over clear
    @(negedge clk); rx_reg_read = 1;
    @(negedge clk); clear_events();
    do_read(4'hC);
    check("R10 clear on rx read", {7'd0, rd_data[0]}, 8'h00);
    @(negedge clk); enter_tx = 1; tx_reg_write = 1;
    @(negedge clk); clear_events();
    do_read(4'hC);
    check("R10 set wins", {7'd0, rd_data[0]}, 8'h01);

    // R12: clock switch
    @(negedge clk); clk_half_done = 1;
    @(negedge clk); clear_events();
    do_read(4'hC);
    check("R12 half done", {7'd0, rd_data[7]}, 8'h01);

    // R11: interface reset dominates
    @(negedge clk); intf_rst = 1; enter_tx = 1; clk_half_done = 1;
    @(negedge clk); clear_events();
    do_read(4'hC);
    check("R11 interface reset", {6'd0, rd_data[7], rd_data[0]}, 8'h00);

    // R12: back to crystal
    @(negedge clk); clk_half_done = 1;
    @(negedge clk); clear_events(); clk_xtal_done = 1;
    @(negedge clk); clear_events();
    do_read(4'hC);
    check("R12 xtal done", {7'd0, rd_data[7]}, 8'h00);

    // R6: fifo empty
    @(negedge clk); fifo_push = 1;
    @(negedge clk); clear_events();
    do_read(4'hC);
    check("R6 one loaded", {7'd0, rd_data[6]}, 8'h00);
    @(negedge clk); fifo_pop = 1;
    @(negedge clk); clear_events();
    do_read(4'hC);
    check("R6 drained", {7'd0, rd_data[6]}, 8'h01);

    // R7: presence
    card_present_raw = 1;
    idle(3);
    do_read(4'hC);
    check("R7 present", {7'd0, rd_data[2]}, 8'h01);

    // R13: other address
    do_read(4'h3);
    check("R13 other address", rd_data, 8'h00);

    // random phase
    void'($urandom(32'h5C0DE));
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (rd_en) begin
        check("R2 valid", {7'd0, rd_valid}, 8'h01);
        check_fields();
      end
      etu_tick      = ($urandom_range(0, 9) < 4);
      if ($urandom_range(0, 29) == 0) io_raw = ~io_raw;
      if ($urandom_range(0, 199) == 0) t1_mode = ~t1_mode;
      if ($urandom_range(0, 99) == 0) card_present_raw = ~card_present_raw;
      intf_rst      = ($urandom_range(0, 49) == 0);
      enter_tx      = ($urandom_range(0, 19) == 0);
      enter_rx      = ($urandom_range(0, 19) == 0);
      tx_char_done  = ($urandom_range(0, 9) == 0);
      tx_parity_err = ($urandom_range(0, 3) == 0);
      last_char_ctl = ($urandom_range(0, 1) == 0);
      rx_buf_full   = ($urandom_range(0, 24) == 0);
      tx_reg_write  = ($urandom_range(0, 14) == 0);
      rx_reg_read   = ($urandom_range(0, 14) == 0);
      fifo_push     = ($urandom_range(0, 5) == 0);
      fifo_pop      = ($urandom_range(0, 5) == 0);
      clk_half_done = ($urandom_range(0, 29) == 0);
      clk_xtal_done = ($urandom_range(0, 29) == 0);
      rd_en         = ($urandom_range(0, 9) < 4);
      rd_addr       = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 15)) : 4'hC;
    end
    @(negedge clk);
    rd_en = 0;
    clear_events();
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule